// File: doc/BRIEF.md
# Direct Mapped Write-Through Data Cache

This block is a physically addressed data cache placed after the address translation stage. It is direct mapped and each line holds a single 32-bit word, with its own valid bit and tag. A requester presents a physical address together with a read or write request, and holds the request while `cpu_stall` is high. A read that hits returns its word in the same cycle, with `cpu_hit` raised. A read that misses stalls the requester. The word is then fetched over a simple memory request/response port and installed in the line. On the following cycle the held read hits.

Writes follow a write-through policy. A write does not look up the line. It overwrites the indexed line's data and tag, marks the line valid, and queues the word address and data in a small FIFO that drains toward memory. Lines are therefore never dirty, and replacing a line never causes a writeback. A read miss waits until the FIFO is empty before it asks memory, so a read can never overtake an older pending write.

Top module: `wt_dcache`

## Requirements
- R1: The physical address splits into a tag in bits 31..INDEX_W+2, an index in bits INDEX_W+1..2 and a byte offset in bits 1..0. INDEX_W is a parameter (with INDEX_W = 14 the tag is 16 bits wide). The index selects exactly one line, and a single tag comparison decides a hit.
- R2: After reset every line is invalid and the write FIFO is empty. With no request pending, `cpu_stall`, `cpu_hit` and `mem_req` are all 0, and the first read of any address misses.
- R3: A read whose line is valid with a matching tag raises `cpu_hit` in the same cycle, drives the stored word on `cpu_rdata`, keeps `cpu_stall` low and issues no memory read.
- R4: An accepted write stores its data and tag in the indexed line and marks it valid, whatever the line held before. A later read of the same word hits with the new data. A write to another tag at the same index evicts the earlier word, so the earlier word then misses.
- R5: Each accepted write pushes its word address (offset 00) and data into the write FIFO. Entries leave in order as memory writes (`mem_req`=1, `mem_we`=1, `mem_addr`, `mem_wdata`). Each entry is removed in a cycle where `mem_gnt` is 1.
- R6: The FIFO holds FIFO_DEPTH entries (default 4). A write that arrives while the FIFO is full is stalled and not accepted until an entry has drained.
- R7: A read miss keeps `cpu_stall` high until the word has been installed. Its memory read is issued only once the write FIFO is empty.
- R8: A miss read is issued with `mem_req`=1, `mem_we`=0 and `mem_addr` set to the word address with offset 00, and is held until `mem_gnt`. The word returned with `mem_rvalid` is installed. The next cycle the held read hits and returns that word.
- R9: The write policy is write-through. The memory sees exactly one write per accepted processor write and none on line replacement.
- R10: The byte offset does not take part in lookup or storage. Addresses that differ only in bits 1..0 refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request valid, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Physical byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_hit |
| cpu_hit | output | 1 | Read hit this cycle |
| cpu_stall | output | 1 | Request not accepted this cycle |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
A corrupted tag or valid bit appears at the ports in the very cycle of the next read to that index. Either `cpu_hit` is raised for a word that should miss, or a miss is reported, with the matching memory read one or more cycles later. A wrong FIFO pointer or count shows up on the memory port as soon as that entry drains: the address or data is out of order, a write is missing or repeated, or a read goes out while writes are still queued. The bench compares every memory write against the queue of accepted writes, and checks every returned word against a model image of memory.

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int INDEX_W    = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_hit,
  output logic        cpu_stall,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = 30 - INDEX_W;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_MISS, S_FILL} state_t;

  logic [31:0]      line_data [LINES];
  logic [TAG_W-1:0] line_tag  [LINES];
  logic [LINES-1:0] line_vld;

  logic [29:0]      wq_addr [FIFO_DEPTH];
  logic [31:0]      wq_data [FIFO_DEPTH];
  logic [PTR_W-1:0] wq_head, wq_tail;
  logic [CNT_W-1:0] wq_cnt;

  state_t      st;
  logic [29:0] miss_word;

  logic [INDEX_W-1:0] req_idx, miss_idx;
  logic [TAG_W-1:0]   req_tag, miss_tag;
  logic lookup_hit, wq_empty, wq_full, wr_take, rd_miss, wq_pop, fill_now;
  logic unused_offset;

  assign req_idx   = cpu_addr[INDEX_W+1:2];
  assign req_tag   = cpu_addr[31:INDEX_W+2];
  assign miss_idx  = miss_word[INDEX_W-1:0];
  assign miss_tag  = miss_word[29:INDEX_W];
  assign unused_offset = ^cpu_addr[1:0];

  assign lookup_hit = line_vld[req_idx] && (line_tag[req_idx] == req_tag);
  assign wq_empty   = (wq_cnt == '0);
  assign wq_full    = (wq_cnt == FULL_CNT);

  assign wr_take  = (st == S_IDLE) && cpu_req && cpu_we && !wq_full;
  assign rd_miss  = (st == S_IDLE) && cpu_req && !cpu_we && !lookup_hit;
  assign wq_pop   = !wq_empty && mem_gnt;
  assign fill_now = (st == S_FILL) && mem_rvalid;

  assign cpu_rdata = line_data[req_idx];
  assign cpu_hit   = (st == S_IDLE) && cpu_req && !cpu_we && lookup_hit;
  assign cpu_stall = (st != S_IDLE) || (cpu_req && (cpu_we ? wq_full : !lookup_hit));

  assign mem_req   = !wq_empty || (st == S_MISS);
  assign mem_we    = !wq_empty;
  assign mem_addr  = wq_empty ? {miss_word, 2'b00} : {wq_addr[wq_head], 2'b00};
  assign mem_wdata = wq_data[wq_head];

  always_ff @(posedge clk) begin
    if (wr_take) begin
      line_data[req_idx] <= cpu_wdata;
      line_tag[req_idx]  <= req_tag;
    end else if (fill_now) begin
      line_data[miss_idx] <= mem_rdata;
      line_tag[miss_idx]  <= miss_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_vld <= '0;
    end else if (wr_take) begin
      line_vld[req_idx] <= 1'b1;
    end else if (fill_now) begin
      line_vld[miss_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_take) begin
      wq_addr[wq_tail] <= cpu_addr[31:2];
      wq_data[wq_tail] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wq_head <= '0;
      wq_tail <= '0;
      wq_cnt  <= '0;
    end else begin
      if (wr_take) wq_tail <= (wq_tail == LAST_PTR) ? '0 : wq_tail + PTR_ONE;
      if (wq_pop)  wq_head <= (wq_head == LAST_PTR) ? '0 : wq_head + PTR_ONE;
      wq_cnt <= wq_cnt + CNT_W'(wr_take) - CNT_W'(wq_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      miss_word <= '0;
    end else begin
      case (st)
        S_IDLE: if (rd_miss) begin
          st        <= S_MISS;
          miss_word <= cpu_addr[31:2];
        end
        S_MISS: if (wq_empty && mem_gnt) st <= S_FILL;
        S_FILL: if (mem_rvalid) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: a hit never waits and never triggers a memory read
  p_hit_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> (!cpu_stall && !(mem_req && !mem_we)));

  // R4: an accepted write leaves the line valid with its tag and data
  p_write_fills_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> (line_vld[$past(req_idx)] && line_tag[$past(req_idx)] == $past(req_tag)
                 && line_data[$past(req_idx)] == $past(cpu_wdata)));

  // R6: a full queue only shrinks through a drain
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wq_full && !wq_pop) |=> wq_full);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wq_cnt <= FULL_CNT);

  // R7: while a miss is outstanding the requester is held
  p_miss_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> cpu_stall);

  // R8: an ungranted read request is held with a stable address
  p_read_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !mem_gnt) |=> (mem_req && !mem_we && $stable(mem_addr)));

  // R8: returned word is installed and the block goes idle
  p_fill_installs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_now |=> (st == S_IDLE && line_vld[$past(miss_idx)]
                  && line_tag[$past(miss_idx)] == $past(miss_tag)));
endmodule

// File: tb/wt_dcache_bench.sv
`timescale 1ns/1ps
module wt_dcache_bench;
  localparam int IW = 6;
  localparam int LAT = 2;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata;
  logic cpu_hit, cpu_stall, mem_req, mem_we;
  logic mem_gnt = 0, mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;

  wt_dcache #(.INDEX_W(IW), .FIFO_DEPTH(4)) u_wt_dcache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  always #10 clk = ~clk;

  int nchk = 0, nbad = 0;
  int gnt_mode = 1;
  int cyc = 0;
  int stall_cnt = 0;
  int cpu_writes = 0, mem_writes = 0;
  logic [63:0] exp_q[$];
  logic [31:0] ref_img [logic [29:0]];
  logic [31:0] mem_img [logic [29:0]];

  function automatic logic [31:0] init_word(input logic [29:0] w);
    return {w[29:0], 2'b00} ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] ref_word(input logic [29:0] w);
    if (ref_img.exists(w)) return ref_img[w];
    return init_word(w);
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory model and write monitor (scoreboard consumer)
  initial begin
    logic        rd_pend;
    logic [29:0] rd_word;
    int          rd_wait;
    rd_pend = 0; rd_word = 0; rd_wait = 0;
    forever begin
      @(negedge clk); #2;
      cyc++;
      mem_rvalid = 0;
      mem_rdata  = 0;
      if (rd_pend) begin
        if (rd_wait == 0) begin
          mem_rvalid = 1;
          mem_rdata  = mem_img.exists(rd_word) ? mem_img[rd_word] : init_word(rd_word);
          rd_pend = 0;
        end else rd_wait--;
      end
      mem_gnt = (gnt_mode == 1) || (gnt_mode == 2 && cyc[0]);
      if (rst_n && mem_req && mem_gnt) begin
        if (mem_we) begin
          mem_writes++;
          if (exp_q.size() == 0) begin
            check("R9 unexpected memory write", mem_addr, 32'hFFFF_FFFF);
          end else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            check("R5 write address order", mem_addr, e[63:32]);
            check("R5 write data order", mem_wdata, e[31:0]);
          end
          mem_img[mem_addr[31:2]] = mem_wdata;
        end else begin
          check("R7 read issued with writes queued", 32'(exp_q.size()), 32'd0);
          check("R8 read address offset", {30'd0, mem_addr[1:0]}, 32'd0);
          rd_pend = 1; rd_word = mem_addr[31:2]; rd_wait = LAT;
        end
      end
    end
  end

  task automatic cpu_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    #3;
    stall_cnt = 0;
    while (cpu_stall) begin
      stall_cnt++;
      @(negedge clk); #4;
    end
    exp_q.push_back({a[31:2], 2'b00, d});
    ref_img[a[31:2]] = d;
    cpu_writes++;
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic cpu_read(input logic [31:0] a, input logic first_hit, input string rq);
    @(negedge clk); #1;
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    #3;
    check({rq, " first-cycle hit"}, {31'd0, cpu_hit}, {31'd0, first_hit});
    stall_cnt = 0;
    while (cpu_stall) begin
      stall_cnt++;
      @(negedge clk); #4;
    end
    check({rq, " final hit"}, {31'd0, cpu_hit}, 32'd1);
    check({rq, " data"}, cpu_rdata, ref_word(a[31:2]));
    @(posedge clk); #1;
    cpu_req = 0;
  endtask

  localparam logic [31:0] STRIDE = 32'(1) << (IW + 2);

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #4;
    // R2: idle after reset
    check("R2 stall idle", {31'd0, cpu_stall}, 32'd0);
    check("R2 hit idle", {31'd0, cpu_hit}, 32'd0);
    check("R2 mem_req idle", {31'd0, mem_req}, 32'd0);

    // R2 R7 R8: cold read misses, then returns memory word
    cpu_read(32'h0000_0040, 1'b0, "R2 R8 cold read");
    check("R7 miss stalled", {31'd0, stall_cnt > 0}, 32'd1);
    // R3 and R10: same word, other offsets, hit at once
    cpu_read(32'h0000_0040, 1'b1, "R3 repeat read");
    cpu_read(32'h0000_0043, 1'b1, "R10 offset read");

    // R4 R5: write then read hits with new data
    cpu_write(32'h0000_0080, 32'hCAFE_0001);
    check("R6 write accepted at once", 32'(stall_cnt), 32'd0);
    cpu_read(32'h0000_0080, 1'b1, "R4 read after write");
    // R10: write through offset 2 lands at the word address
    cpu_write(32'h0000_0082, 32'hCAFE_0002);
    cpu_read(32'h0000_0081, 1'b1, "R10 offset write");

    // R4 R9: conflicting tag at same index evicts, no writeback
    cpu_write(32'h0000_0080 + STRIDE, 32'hBEEF_0003);
    cpu_read(32'h0000_0080 + STRIDE, 1'b1, "R4 new tag hits");
    cpu_read(32'h0000_0080, 1'b0, "R4 evicted word misses");

    // R1: all-ones index with two tags
    cpu_read(32'hFFFF_FFFC, 1'b0, "R1 top index cold");
    cpu_write(32'h0000_00FC, 32'h1234_5678);
    cpu_read(32'hFFFF_FFFC, 1'b0, "R1 top index evicted");
    cpu_read(32'h7FFF_FFFC, 1'b0, "R1 tag bit 31 differs");

    // R6: fill the queue with memory blocked, fifth write stalls
    gnt_mode = 0;
    for (int i = 0; i < 4; i++) begin
      cpu_write(32'h0000_0200 + 32'(i) * 4, 32'hA000_0000 + 32'(i));
      check("R6 write below full", 32'(stall_cnt), 32'd0);
    end
    fork
      cpu_write(32'h0000_0210, 32'hA000_0004);
      begin repeat (5) @(negedge clk); gnt_mode = 1; end
    join
    check("R6 full write stalled", {31'd0, stall_cnt >= 3}, 32'd1);
    cpu_read(32'h0000_0210, 1'b1, "R6 stalled write stored");

    // R7: read miss waits for queued writes to drain
    gnt_mode = 0;
    cpu_write(32'h0000_0300, 32'hD000_0001);
    cpu_write(32'h0000_0300 + STRIDE, 32'hD000_0002);
    fork
      cpu_read(32'h0000_0300, 1'b0, "R7 read behind writes");
      begin repeat (4) @(negedge clk); gnt_mode = 1; end
    join
    check("R7 read held while blocked", {31'd0, stall_cnt >= 4}, 32'd1);

    // R5 R8 R9: slow alternating grant, many writes then conflicting reads
    gnt_mode = 2;
    for (int i = 0; i < 12; i++)
      cpu_write(32'h0000_1000 + 32'(i) * 4, 32'hE000_0000 + 32'(i) * 3);
    for (int i = 0; i < 12; i++)
      cpu_read(32'h0000_1000 + 32'(i) * 4, 1'b1, "R4 slow grant hits");
    for (int i = 0; i < 12; i += 3)
      cpu_read(32'h0000_2000 + 32'(i) * 4, 1'b0, "R8 slow grant miss");
    for (int i = 0; i < 12; i += 3)
      cpu_read(32'h0000_1000 + 32'(i) * 4, 1'b0, "R9 refetch written word");

    gnt_mode = 1;
    repeat (20) @(negedge clk);
    check("R5 queue drained", 32'(exp_q.size()), 32'd0);
    check("R9 one memory write per store", 32'(mem_writes), 32'(cpu_writes));

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule